// File: doc/BRIEF.md
# In-Order Credit Tracker

This block regulates how many commands a source may have in flight toward a downstream unit that finishes its work strictly in issue order. It holds a pool of credits that starts full at `CAP`. Each accepted command spends one credit, and each accepted response returns one. The command ready is withheld whenever the pool is empty. The response ready is withheld whenever nothing is outstanding.

Every accepted command is labelled with the running issue sequence number, which appears on `cmd_tag`. The tracker also keeps a running retire sequence number, shown on `rsp_exp_tag`. An accepted response must carry a tag equal to that number. If the tag differs, the completion is out of order and `order_err` pulses for one cycle. The response is still retired, so the credit pool and both counters stay consistent with each other. Both sequence numbers wrap modulo 2^`SEQ_W`. The tag comparison uses the same width, so the wrap point needs no special handling.

Top module: `inorder_credit_tracker`

## Requirements
- R1: While reset is asserted and right after it, `credits` equals `CAP`, `cmd_tag` and `rsp_exp_tag` are 0, `order_err` is 0, `cmd_rdy` is 1 and `rsp_rdy` is 0.
- R2: `cmd_rdy` is 0 exactly when `credits` is 0. A `cmd_vld` presented with no credit causes no issue and changes neither `credits` nor `cmd_tag`.
- R3: `credits` never exceeds `CAP`. `rsp_rdy` is 0 when `credits` equals `CAP`, and a `rsp_vld` in that state is ignored.
- R4: An issue (`cmd_vld && cmd_rdy`) without a retire lowers `credits` by one and advances `cmd_tag` by one on the next cycle.
- R5: A retire (`rsp_vld && rsp_rdy`) without an issue raises `credits` by one and advances `rsp_exp_tag` by one on the next cycle.
- R6: An issue and a retire in the same cycle leave `credits` unchanged while both tags advance.
- R7: In every cycle, `credits` equals `CAP` minus (`cmd_tag` minus `rsp_exp_tag`), with the subtraction taken modulo 2^`SEQ_W`.
- R8: A retire whose `rsp_tag` differs from `rsp_exp_tag` raises `order_err` for exactly the following cycle and still counts as a retire. At all other times `order_err` is 0.
- R9: `cmd_tag` and `rsp_exp_tag` wrap from all-ones to 0. In-order traffic across the wrap raises no `order_err`.
- R10: With `CAP` = 2, the issue pattern 1,1,0,1,0,0 and the retire pattern 0,0,1,0,1,1 give `credits` sampled before each edge of 2,1,0,1,0,1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_vld | input | 1 | Source offers a command |
| cmd_rdy | output | 1 | A credit is available; the command is accepted |
| cmd_tag | output | SEQ_W | Sequence number given to the command accepted in this cycle |
| rsp_vld | input | 1 | Downstream offers a response |
| rsp_rdy | output | 1 | At least one command is outstanding |
| rsp_tag | input | SEQ_W | Tag carried by the response |
| rsp_exp_tag | output | SEQ_W | Retire sequence number the next response must carry |
| credits | output | $clog2(CAP+1) | Current free credits |
| order_err | output | 1 | One-cycle pulse after an out-of-order response |

## Verification
A corrupted credit register breaks the link between `credits` and the difference of the two exposed tags in the very next cycle. It also flips `cmd_rdy` or `rsp_rdy` away from the values the pool level implies. A slipped issue or retire counter shows on `cmd_tag` or `rsp_exp_tag` at once. It then raises a false `order_err` one cycle after the next response. A wrong decision in the tag comparator is visible one cycle after the offending response, because the error register sits directly on the port.

// File: rtl/trk_pkg.sv
package trk_pkg;

   // Handshake events of one cycle, passed to the credit pool.
   typedef struct packed {
      logic issue;
      logic retire;
   } trk_xfer_t;

   // Width needed to hold the values 0..cap.
   function automatic int trk_cnt_w(input int cap);
      return (cap < 1) ? 1 : $clog2(cap + 1);
   endfunction

endpackage

// File: rtl/trk_seq_counter.sv
module trk_seq_counter #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         inc,
   output logic [W-1:0] count
);

   logic [W-1:0] count_q;

   // Free-running modulo-2^W counter.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   count_q <= '0;
      else if (inc) count_q <= count_q + W'(1);
   end

   assign count = count_q;

endmodule

// File: rtl/trk_credit_pool.sv
module trk_credit_pool
   import trk_pkg::*;
#(
   parameter int CAP = 2,
   localparam int CW = trk_cnt_w(CAP)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  trk_xfer_t     ev,
   output logic [CW-1:0] credits,
   output logic          has_credit,
   output logic          all_free
);

   generate
      if (CAP == 1) begin : g_single
         // One credit needs only a free/busy flag.
         logic free_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                      free_q <= 1'b1;
            else if (ev.issue && !ev.retire) free_q <= 1'b0;
            else if (ev.retire && !ev.issue) free_q <= 1'b1;
         end
         assign credits = CW'(free_q);
      end else begin : g_multi
         logic [CW-1:0] cnt_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) cnt_q <= CW'(CAP);
            else begin
               unique case ({ev.issue, ev.retire})
                  2'b10:   cnt_q <= cnt_q - CW'(1);
                  2'b01:   cnt_q <= cnt_q + CW'(1);
                  default: cnt_q <= cnt_q;   // idle, or issue and retire together
               endcase
            end
         end
         assign credits = cnt_q;
      end
   endgenerate

   assign has_credit = (credits != '0);
   assign all_free   = (credits == CW'(CAP));

endmodule

// File: rtl/trk_tag_check.sv
module trk_tag_check #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         retire,
   input  logic [W-1:0] tag,
   input  logic [W-1:0] expected,
   output logic         err
);

   logic err_q;

   // Registered pulse: high for the single cycle after a mismatched retire.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) err_q <= 1'b0;
      else        err_q <= retire && (tag != expected);
   end

   assign err = err_q;

endmodule

// File: rtl/inorder_credit_tracker.sv
module inorder_credit_tracker
   import trk_pkg::*;
#(
   parameter int CAP   = 2,
   parameter int SEQ_W = 32,
   localparam int CRD_W = trk_cnt_w(CAP)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmd_vld,
   output logic             cmd_rdy,
   output logic [SEQ_W-1:0] cmd_tag,
   input  logic             rsp_vld,
   output logic             rsp_rdy,
   input  logic [SEQ_W-1:0] rsp_tag,
   output logic [SEQ_W-1:0] rsp_exp_tag,
   output logic [CRD_W-1:0] credits,
   output logic             order_err
);

   // Elaboration-time parameter checks.
   generate
      if (CAP < 1) begin : g_bad_cap
         $error("CAP must be at least 1");
      end
      if (SEQ_W <= CRD_W) begin : g_bad_seq
         $error("SEQ_W must be wider than the credit counter");
      end
   endgenerate

   trk_xfer_t ev;
   logic      has_credit;
   logic      all_free;

   assign ev.issue  = cmd_vld && has_credit;
   assign ev.retire = rsp_vld && !all_free;

   trk_credit_pool #(.CAP(CAP)) u_pool (
      .clk        (clk),
      .rst_n      (rst_n),
      .ev         (ev),
      .credits    (credits),
      .has_credit (has_credit),
      .all_free   (all_free)
   );

   trk_seq_counter #(.W(SEQ_W)) u_issue_seq (
      .clk   (clk),
      .rst_n (rst_n),
      .inc   (ev.issue),
      .count (cmd_tag)
   );

   trk_seq_counter #(.W(SEQ_W)) u_retire_seq (
      .clk   (clk),
      .rst_n (rst_n),
      .inc   (ev.retire),
      .count (rsp_exp_tag)
   );

   trk_tag_check #(.W(SEQ_W)) u_tag_check (
      .clk      (clk),
      .rst_n    (rst_n),
      .retire   (ev.retire),
      .tag      (rsp_tag),
      .expected (rsp_exp_tag),
      .err      (order_err)
   );

   assign cmd_rdy = has_credit;
   assign rsp_rdy = !all_free;

endmodule

// File: rtl/trk_checker.sv
module trk_checker #(
   parameter int CAP   = 2,
   parameter int SEQ_W = 32,
   localparam int CRD_W = trk_pkg::trk_cnt_w(CAP)
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cmd_vld,
   input logic             cmd_rdy,
   input logic [SEQ_W-1:0] cmd_tag,
   input logic             rsp_vld,
   input logic             rsp_rdy,
   input logic [SEQ_W-1:0] rsp_tag,
   input logic [SEQ_W-1:0] rsp_exp_tag,
   input logic [CRD_W-1:0] credits,
   input logic             order_err
);

   logic iss, ret, mism;
   logic [SEQ_W-1:0] outstanding;
   assign iss         = cmd_vld && cmd_rdy;
   assign ret         = rsp_vld && rsp_rdy;
   assign mism        = ret && (rsp_tag != rsp_exp_tag);
   assign outstanding = cmd_tag - rsp_exp_tag;

   p_empty_blocks_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (credits == '0) |-> !cmd_rdy);
   p_credit_opens_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (credits != '0) |-> cmd_rdy);
   p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
      credits <= CRD_W'(CAP));
   p_idle_no_retire_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (credits == CRD_W'(CAP)) |-> !rsp_rdy);
   p_issue_spends_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (iss && !ret) |=> (credits == $past(credits) - CRD_W'(1)));
   p_issue_tag_r4: assert property (@(posedge clk) disable iff (!rst_n)
      iss |=> (cmd_tag == $past(cmd_tag) + SEQ_W'(1)));
   p_retire_returns_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (ret && !iss) |=> (credits == $past(credits) + CRD_W'(1)));
   p_retire_tag_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ret |=> (rsp_exp_tag == $past(rsp_exp_tag) + SEQ_W'(1)));
   p_both_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (iss && ret) |=> $stable(credits));
   p_conserve_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (SEQ_W'(credits) + outstanding) == SEQ_W'(CAP));
   p_err_raise_r8: assert property (@(posedge clk) disable iff (!rst_n)
      mism |=> order_err);
   p_err_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !mism |=> !order_err);
   p_wrap_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (iss && (cmd_tag == '1)) |=> (cmd_tag == '0));

endmodule

bind inorder_credit_tracker trk_checker #(.CAP(CAP), .SEQ_W(SEQ_W)) u_trk_checker (
   .clk         (clk),
   .rst_n       (rst_n),
   .cmd_vld     (cmd_vld),
   .cmd_rdy     (cmd_rdy),
   .cmd_tag     (cmd_tag),
   .rsp_vld     (rsp_vld),
   .rsp_rdy     (rsp_rdy),
   .rsp_tag     (rsp_tag),
   .rsp_exp_tag (rsp_exp_tag),
   .credits     (credits),
   .order_err   (order_err)
);

// File: tb/inorder_credit_tracker_test.sv
module inorder_credit_tracker_test;

   localparam int CAP   = 2;
   localparam int SEQ_W = 4;
   localparam int CRD_W = 2;

   logic             clk = 1'b0;
   logic             rst_n;
   logic             cmd_vld, rsp_vld;
   logic             cmd_rdy, rsp_rdy, order_err;
   logic [SEQ_W-1:0] cmd_tag, rsp_tag, rsp_exp_tag;
   logic [CRD_W-1:0] credits;

   int tests = 0;
   int fails = 0;

   // Bench reference model, built from the requirements.
   int               cr_m  = CAP;
   logic [SEQ_W-1:0] iss_m = '0;
   logic [SEQ_W-1:0] ret_m = '0;
   logic             err_m = 1'b0;

   always #10 clk = ~clk;   // 50 MHz

   inorder_credit_tracker #(.CAP(CAP), .SEQ_W(SEQ_W)) uut (
      .clk(clk), .rst_n(rst_n), .cmd_vld(cmd_vld), .cmd_rdy(cmd_rdy),
      .cmd_tag(cmd_tag), .rsp_vld(rsp_vld), .rsp_rdy(rsp_rdy),
      .rsp_tag(rsp_tag), .rsp_exp_tag(rsp_exp_tag), .credits(credits),
      .order_err(order_err)
   );

   typedef struct packed {
      logic       cmd;
      logic       rsp;
      logic       bad;
      logic [1:0] cr;    // credits expected before the edge
      logic       err;   // order_err expected before the edge
   } vec_t;

   localparam vec_t VECS [15] = '{
      '{1'b1, 1'b0, 1'b0, 2'd2, 1'b0},   // R10 sequence starts
      '{1'b1, 1'b0, 1'b0, 2'd1, 1'b0},
      '{1'b0, 1'b1, 1'b0, 2'd0, 1'b0},
      '{1'b1, 1'b0, 1'b0, 2'd1, 1'b0},
      '{1'b0, 1'b1, 1'b0, 2'd0, 1'b0},
      '{1'b0, 1'b1, 1'b0, 2'd1, 1'b0},
      '{1'b0, 1'b1, 1'b0, 2'd2, 1'b0},   // R3 response at full pool ignored
      '{1'b1, 1'b0, 1'b0, 2'd2, 1'b0},
      '{1'b1, 1'b1, 1'b0, 2'd1, 1'b0},   // R6 issue and retire together
      '{1'b0, 1'b0, 1'b0, 2'd1, 1'b0},
      '{1'b1, 1'b0, 1'b0, 2'd1, 1'b0},
      '{1'b1, 1'b0, 1'b0, 2'd0, 1'b0},   // R2 command with no credit ignored
      '{1'b0, 1'b1, 1'b1, 2'd0, 1'b0},   // R8 wrong tag
      '{1'b0, 1'b1, 1'b0, 2'd1, 1'b1},   // R8 pulse visible
      '{1'b0, 1'b0, 1'b0, 2'd2, 1'b0}
   };

   task automatic chk(input string req, input string what, input int act, input int exp);
      tests++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic check_state();
      chk("R7", "credits", int'(credits), cr_m);
      chk("R2", "cmd_rdy", int'(cmd_rdy), int'(cr_m != 0));
      chk("R3", "rsp_rdy", int'(rsp_rdy), int'(cr_m != CAP));
      chk("R4", "cmd_tag", int'(cmd_tag), int'(iss_m));
      chk("R5", "rsp_exp_tag", int'(rsp_exp_tag), int'(ret_m));
      chk("R8", "order_err", int'(order_err), int'(err_m));
   endtask

   // Drive one cycle from a falling edge to the next falling edge.
   task automatic step(input logic c, input logic r, input logic b);
      logic iss, ret;
      iss     = c && (cr_m != 0);
      ret     = r && (cr_m != CAP);
      cmd_vld = c;
      rsp_vld = r;
      rsp_tag = b ? ret_m + SEQ_W'(1) : ret_m;
      @(negedge clk);
      cmd_vld = 1'b0;
      rsp_vld = 1'b0;
      if (iss) begin iss_m = iss_m + SEQ_W'(1); cr_m = cr_m - 1; end
      if (ret) begin ret_m = ret_m + SEQ_W'(1); cr_m = cr_m + 1; end
      err_m = ret && b;
   endtask

   task automatic reset_model();
      cr_m = CAP; iss_m = '0; ret_m = '0; err_m = 1'b0;
   endtask

   initial begin
      #(200000 * 20);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      rst_n = 1'b0; cmd_vld = 1'b0; rsp_vld = 1'b0; rsp_tag = '0;
      repeat (3) @(negedge clk);
      // R1 values while reset is held
      chk("R1", "credits", int'(credits), CAP);
      chk("R1", "cmd_tag", int'(cmd_tag), 0);
      chk("R1", "rsp_exp_tag", int'(rsp_exp_tag), 0);
      chk("R1", "order_err", int'(order_err), 0);
      chk("R1", "cmd_rdy", int'(cmd_rdy), 1);
      chk("R1", "rsp_rdy", int'(rsp_rdy), 0);
      rst_n = 1'b1;
      @(negedge clk);

      // Table walk: R10 sequence, then R3, R6, R2, R8 corners.
      for (int i = 0; i < 15; i++) begin
         chk("R10", "table credits", int'(credits), int'(VECS[i].cr));
         chk("R8", "table order_err", int'(order_err), int'(VECS[i].err));
         check_state();
         step(VECS[i].cmd, VECS[i].rsp, VECS[i].bad);
      end
      check_state();

      // R4: a lone issue spends a credit and advances cmd_tag.
      step(1'b1, 1'b0, 1'b0);
      chk("R4", "credits after issue", int'(credits), CAP - 1);
      check_state();
      // R5: a lone retire returns the credit and advances rsp_exp_tag.
      step(1'b0, 1'b1, 1'b0);
      chk("R5", "credits after retire", int'(credits), CAP);
      check_state();
      // R6: issue and retire together keep the level.
      step(1'b1, 1'b0, 1'b0);
      step(1'b1, 1'b1, 1'b0);
      chk("R6", "credits with both", int'(credits), CAP - 1);
      check_state();

      // R9: run both counters past the wrap with in-order tags.
      for (int k = 0; k < 20; k++) begin
         step(1'b1, 1'b1, 1'b0);
         chk("R9", "no order_err across wrap", int'(order_err), 0);
         check_state();
      end
      step(1'b0, 1'b1, 1'b0);
      check_state();

      // R1 again: reset during traffic.
      step(1'b1, 1'b0, 1'b0);
      rst_n = 1'b0;
      @(negedge clk);
      reset_model();
      chk("R1", "credits after mid reset", int'(credits), CAP);
      check_state();
      rst_n = 1'b1;
      @(negedge clk);
      check_state();

      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule